// File: doc/BRIEF.md
# Framed 24-bit Serial Word Receiver

This block takes a three-wire serial link (an active-low frame select, a serial clock and one data line) and turns each frame into a 24-bit parallel word. All three pins are oversampled by the fast system clock. Each pin passes through a two-stage synchronizer, and the block finds serial-clock edges by comparing successive samples. For that to work, the system clock must run at least four times faster than the serial clock. Only falling serial-clock edges seen while the frame select is low shift data in, most significant bit first. The serial clock may idle at either level or run without stopping. No rising edge is needed before the first capture.

Once 24 bits are in, the word goes to the output register, and a valid strobe is high for exactly one system cycle. The output is a pure stream source: the serial sender cannot be paused, so there is no ready input and no back-pressure. A consumer must accept the word in the cycle the strobe is high. The word stays on the output until the next complete frame replaces it. If the frame select rises before the 24th bit arrives, the partial word is dropped and an error strobe is high for one cycle.

Top module: `sfr_rx`

## Requirements
- R1: The word is 24 bits and arrives MSB first: the first captured bit ends up in word bit 23 and the last in bit 0.
- R2: Data is sampled on falling serial-clock edges only. The data level around a rising edge has no effect on the word.
- R3: The first falling serial-clock edge after the frame select goes low captures bit 23. This holds whether the serial clock was high or low when the select fell.
- R4: Serial-clock edges while the frame select is high produce no strobe and no error, and they do not disturb the next frame.
- R5: After the 24th captured bit, `word_out` takes the new value and `word_valid` is high for exactly one system cycle. In every other cycle `word_out` holds its value.
- R6: Every falling edge inside a frame counts as a bit until 24 are captured. An extra early edge therefore shifts the word. Falling edges after the 24th are ignored until the select rises, and they cause neither a second strobe nor an error.
- R7: If the select rises after fewer than 24 captured bits (zero included), `frame_err` is high for one cycle, `word_valid` stays low, and `word_out` is unchanged.
- R8: The bit count and the partial word are cleared while the select is high, so a frame that follows an aborted one is received correctly.
- R9: During and after reset, `word_valid` and `frame_err` are 0 and `word_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_sel_n | input | 1 | Active-low frame select pin (asynchronous) |
| ser_clk | input | 1 | Serial clock pin (asynchronous) |
| ser_data | input | 1 | Serial data pin (asynchronous) |
| word_out | output | 24 | Last complete received word |
| word_valid | output | 1 | One-cycle strobe: `word_out` updated, no back-pressure |
| frame_err | output | 1 | One-cycle strobe: frame ended before 24 bits |

## Verification
The bench starts frames with the serial clock idling both high and low. A design that waited for a rising edge would lose bit 23 when the clock was already high. One test changes the data line just after each rising edge, so a design that samples on the wrong edge receives inverted bits. Frames with one extra leading edge and with extra trailing edges are sent. Leading extras must shift the word; trailing extras must not give a second strobe. Aborted frames, including one with no bits, must raise the error with the word unchanged, and the frame after them must come out clean. A design that kept stale count or data across the idle gap would corrupt that next frame.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
  localparam int unsigned DEF_WORD_W = 24;

  // events produced by the edge detector for the shift core
  typedef struct packed {
    logic sel_act;   // synchronized frame select is low
    logic sel_rise;  // frame select just went high
    logic clk_fall;  // serial clock just fell
    logic bit_in;    // synchronized data sample aligned with clk_fall
  } sfr_evt_t;
endpackage

// File: rtl/sfr_pin_sync.sv
module sfr_pin_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] pin_sync
);
  logic [STAGES-1:0][WIDTH-1:0] stg;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[0] <= RST_VAL;
        else        stg[0] <= pin_in;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg <= {STAGES{RST_VAL}};
        else        stg <= {stg[STAGES-2:0], pin_in};
      end
    end
  endgenerate

  assign pin_sync = stg[STAGES-1];
endmodule

// File: rtl/sfr_edge_det.sv
module sfr_edge_det
  import sfr_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     sel_n_s,
  input  logic     sclk_s,
  input  logic     data_s,
  output sfr_evt_t evt
);
  logic sclk_prev;
  logic sel_n_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_prev  <= 1'b0;
      sel_n_prev <= 1'b1;
    end else begin
      sclk_prev  <= sclk_s;
      sel_n_prev <= sel_n_s;
    end
  end

  always_comb begin
    evt.sel_act  = ~sel_n_s;
    evt.sel_rise = sel_n_s & ~sel_n_prev;
    evt.clk_fall = sclk_prev & ~sclk_s;
    evt.bit_in   = data_s;
  end
endmodule

// File: rtl/sfr_shift_core.sv
module sfr_shift_core
  import sfr_pkg::*;
#(
  parameter int unsigned WORD_W = DEF_WORD_W,
  localparam int unsigned CNT_W = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  sfr_evt_t          evt,
  output logic [WORD_W-1:0] word_q,
  output logic              valid_q,
  output logic              err_q,
  output logic [CNT_W-1:0]  bit_cnt
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic [WORD_W-1:0] shreg;
  logic [WORD_W-1:0] shreg_nx;

  assign shreg_nx = {shreg[WORD_W-2:0], evt.bit_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg   <= '0;
      bit_cnt <= '0;
      word_q  <= '0;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      err_q   <= 1'b0;
      if (!evt.sel_act) begin
        shreg   <= '0;
        bit_cnt <= '0;
        if (evt.sel_rise && bit_cnt != FULL) err_q <= 1'b1;
      end else if (evt.clk_fall && bit_cnt != FULL) begin
        shreg   <= shreg_nx;
        bit_cnt <= bit_cnt + 1'b1;
        if (bit_cnt == LAST) begin
          word_q  <= shreg_nx;
          valid_q <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sfr_rx.sv
module sfr_rx
  import sfr_pkg::*;
#(
  parameter int unsigned WORD_W      = DEF_WORD_W,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_sel_n,
  input  logic              ser_clk,
  input  logic              ser_data,
  output logic [WORD_W-1:0] word_out,
  output logic              word_valid,
  output logic              frame_err
);
  localparam int unsigned CNT_W = $clog2(WORD_W + 1);

  logic [2:0]       pins_s;
  sfr_evt_t         evt;
  logic [CNT_W-1:0] bit_cnt;
  logic             cs_active;

  sfr_pin_sync #(
    .WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)
  ) u_sync (
    .clk(clk), .rst_n(rst_n),
    .pin_in({frame_sel_n, ser_clk, ser_data}),
    .pin_sync(pins_s)
  );

  sfr_edge_det u_edge (
    .clk(clk), .rst_n(rst_n),
    .sel_n_s(pins_s[2]), .sclk_s(pins_s[1]), .data_s(pins_s[0]),
    .evt(evt)
  );

  sfr_shift_core #(.WORD_W(WORD_W)) u_core (
    .clk(clk), .rst_n(rst_n), .evt(evt),
    .word_q(word_out), .valid_q(word_valid), .err_q(frame_err),
    .bit_cnt(bit_cnt)
  );

  assign cs_active = evt.sel_act;
endmodule

// File: rtl/sfr_rx_chk.sv
module sfr_rx_chk #(
  parameter int unsigned WORD_W = 24,
  localparam int unsigned CNT_W = $clog2(WORD_W + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [WORD_W-1:0] word,
  input logic              valid,
  input logic              err,
  input logic              cs_act,
  input logic [CNT_W-1:0]  bit_cnt
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  p_valid_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid);
  p_word_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> $stable(word));
  p_valid_after_last_r1: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> $past(bit_cnt) == LAST);
  p_err_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !err);
  p_err_short_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> ($past(bit_cnt) != FULL) && !valid);
  p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= FULL);
  p_cnt_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> bit_cnt == '0);
endmodule

bind sfr_rx sfr_rx_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .word(word_out), .valid(word_valid),
  .err(frame_err), .cs_act(cs_active), .bit_cnt(bit_cnt)
);

// File: tb/sfr_rx_bench.sv
module sfr_rx_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_sel_n = 1'b1;
  logic        ser_clk = 1'b0;
  logic        ser_data = 1'b0;
  logic [23:0] word_out;
  logic        word_valid;
  logic        frame_err;

  int n_chk = 0;
  int n_bad = 0;
  int n_valid = 0;
  int n_err = 0;
  logic [23:0] last_word = '0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  sfr_rx u_sfr_rx (
    .clk(clk), .rst_n(rst_n), .frame_sel_n(frame_sel_n),
    .ser_clk(ser_clk), .ser_data(ser_data),
    .word_out(word_out), .word_valid(word_valid), .frame_err(frame_err)
  );

  always @(negedge clk) begin
    if (rst_n && word_valid) begin n_valid++; last_word = word_out; end
    if (rst_n && frame_err)  n_err++;
  end

  typedef struct packed {
    logic [31:0] data;
    logic [5:0]  nbits;
    logic        start_high;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{32'h00A5C396, 6'd24, 1'b0},
    '{32'h005A3C69, 6'd24, 1'b1},
    '{32'h00FFFFFF, 6'd24, 1'b0},
    '{32'h00000001, 6'd24, 1'b1},
    '{32'h01800001, 6'd25, 1'b0},  // extra leading edge shifts word (R6)
    '{32'h02ABCDEF, 6'd26, 1'b1},  // extra trailing edges ignored (R6)
    '{32'h000003FF, 6'd10, 1'b1},  // short frame (R7)
    '{32'h00800000, 6'd24, 1'b0}   // frame after abort (R8)
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // sends nbits from data[nbits-1] down; skew drives the wrong level
  // around the rising edge and the right one just before the falling edge
  task automatic send_frame(input logic [31:0] data, input int nbits,
                            input bit start_high, input bit skew);
    ser_clk = start_high;
    wait_clk(6);
    frame_sel_n = 1'b0;
    wait_clk(4);
    for (int i = nbits - 1; i >= 0; i--) begin
      ser_data = skew ? ~data[i] : data[i];
      ser_clk  = 1'b1;
      wait_clk(4);
      ser_data = data[i];
      wait_clk(4);
      ser_clk = 1'b0;
      wait_clk(4);
    end
    frame_sel_n = 1'b1;
    wait_clk(10);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int v0, e0;
    logic [23:0] exp_word;
    wait_clk(5);
    // R9 reset state
    check("R9 valid", word_valid, 0);
    check("R9 err", frame_err, 0);
    check("R9 word", word_out, 0);
    rst_n = 1'b1;
    wait_clk(5);

    exp_word = '0;
    for (int k = 0; k < NV; k++) begin
      v0 = n_valid; e0 = n_err;
      send_frame(VECS[k].data, int'(VECS[k].nbits), VECS[k].start_high, 1'b0);
      if (VECS[k].nbits >= 24) begin
        exp_word = 24'(VECS[k].data >> (VECS[k].nbits - 24));
        check("R5/R6 valid count", n_valid - v0, 1);
        check("R7 no err", n_err - e0, 0);
        check("R1/R3 word", last_word, exp_word);
      end else begin
        check("R7 no valid", n_valid - v0, 0);
        check("R7 err count", n_err - e0, 1);
        check("R7 word held", word_out, exp_word);
      end
      check("R5 word holds", word_out, exp_word);
    end

    // R4: free-running clock with select high
    v0 = n_valid; e0 = n_err;
    for (int i = 0; i < 30; i++) begin
      ser_data = i[0]; ser_clk = ~ser_clk; wait_clk(4);
    end
    check("R4 no valid", n_valid - v0, 0);
    check("R4 no err", n_err - e0, 0);
    check("R4 word", word_out, exp_word);
    send_frame(32'h00C0FFEE, 24, ser_clk, 1'b0);
    check("R4 frame after free clock", last_word, 24'hC0FFEE);

    // R2: data wrong around rising edges
    v0 = n_valid;
    send_frame(32'h00369CA5, 24, 1'b0, 1'b1);
    check("R2 valid", n_valid - v0, 1);
    check("R2 falling edge sampling", last_word, 24'h369CA5);

    // R7: zero-bit frame
    e0 = n_err; v0 = n_valid;
    send_frame(32'h0, 0, 1'b1, 1'b0);
    check("R7 empty frame err", n_err - e0, 1);
    check("R7 empty frame word", word_out, 24'h369CA5);

    // R8: short frame of ones then full frame of mostly zeros
    send_frame(32'h0000FFFF, 16, 1'b0, 1'b0);
    send_frame(32'h00000003, 24, 1'b1, 1'b0);
    check("R8 clean after abort", last_word, 24'h000003);
    check("R8 valid count", n_valid - v0, 1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule